// File: doc/BRIEF.md
# Code Density Histogrammer

The block measures the bin widths of a fine time-interpolator by the code density method. Events are fed to the measured channel from a source that runs asynchronously to the reference clock, so their arrival phase is spread evenly over one reference period. Each accepted fine code increments the counter of its bin. Given enough hits, every bin's count is proportional to its real width.

A start pulse clears all bins and fixes the hit target N = 2^k. Once N hits are accepted, collection stops and `done` rises. The block then sweeps the bins once. During the sweep it accumulates the integral nonlinearity into a small table and notes whether any bin stayed empty. When the sweep ends, `ready` rises. Any bin can then be read by index: the read returns its count, its differential nonlinearity, its integral nonlinearity and an empty-bin flag.

Top module: `cdt_histogram`

## Requirements
- R1: After reset, `busy`, `done` and `ready` are low.
- R2: A `start` pulse clears every bin, latches the target exponent and raises `busy` on the next cycle. A hit presented in the same cycle as `start` is not counted.
- R3: While `busy` is high, a hit (`code_valid` high) increments the counter of bin `code` by one. Each counter is 20 bits wide and saturates at 2^20-1.
- R4: The target is N = 2^k. `target_log2` is clamped to the range 7..20 to give k. `done` rises, and `busy` falls, on the cycle after the N-th accepted hit, and not earlier.
- R5: A hit that arrives while `busy` is low, including any hit after `done`, leaves every bin count unchanged.
- R6: `rd_dnl` is a signed value with 8 fractional bits, equal to floor((count - N/128) * 128 * 256 / N).
- R7: `rd_inl` for bin i is the sum of the `rd_dnl` values of bins 0 through i, in the same fixed-point format.
- R8: `rd_missing` is 1 exactly when the bin's count is zero. Once `ready` is high, `any_missing` is 1 exactly when at least one bin is zero.
- R9: `ready` rises 128 cycles after `done` rises. It stays high, with `done`, until the next `start`.
- R10: A read shows the data for `rd_idx` one cycle after the index is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear the bins and begin a collection |
| target_log2 | input | 5 | Exponent k of the hit target, sampled on `start` |
| code_valid | input | 1 | Hit strobe |
| code | input | 7 | Fine bin code of the hit |
| rd_idx | input | 7 | Bin selected for readout |
| busy | output | 1 | Collection in progress |
| done | output | 1 | Hit target reached |
| ready | output | 1 | Sweep finished; INL and `any_missing` are valid |
| any_missing | output | 1 | At least one bin received no hit |
| rd_count | output | 20 | Count of the selected bin |
| rd_dnl | output | 17 | DNL of the selected bin, signed, 8 fractional bits |
| rd_inl | output | 24 | INL up to the selected bin, signed, 8 fractional bits |
| rd_missing | output | 1 | Selected bin is empty |

## Verification
The assertions check the control relationships on every cycle:
- the state that follows a start;
- `done` rising only on an accepted hit;
- `busy` and `done` never being high together;
- `ready` implying `done`;
- the empty-bin summary staying steady while results are held.

Only the bench's sweeps can show that the counts, DNL and INL values are right. These sweeps cover:
- a uniform fill with a clamped exponent;
- a fill with one empty bin and one wide bin;
- a large target, where the scaling becomes a flooring right shift.

The bench also confirms that hits in the start cycle or after `done` leave the counts untouched, and it measures the exact delay from `done` to `ready`.

// File: rtl/cdt_histogram.sv
module cdt_histogram #(
  parameter  int BINS  = 128,
  parameter  int CNT_W = 20,
  parameter  int K_W   = 5,
  parameter  int FRAC  = 8,
  localparam int BIN_W = $clog2(BINS),
  localparam int DNL_W = FRAC + BIN_W + 2,
  localparam int INL_W = DNL_W + BIN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [K_W-1:0]          target_log2,
  input  logic                    code_valid,
  input  logic [BIN_W-1:0]        code,
  input  logic [BIN_W-1:0]        rd_idx,
  output logic                    busy,
  output logic                    done,
  output logic                    ready,
  output logic                    any_missing,
  output logic [CNT_W-1:0]        rd_count,
  output logic signed [DNL_W-1:0] rd_dnl,
  output logic signed [INL_W-1:0] rd_inl,
  output logic                    rd_missing
);

  localparam int K_MIN = BIN_W;
  localparam int K_MAX = CNT_W;
  localparam int SCALE = FRAC + BIN_W;
  localparam int WIDE  = CNT_W + SCALE + 2;

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_SWEEP, S_HOLD} state_t;

  state_t                  state;
  logic [CNT_W-1:0]        bin_cnt [BINS];
  logic signed [INL_W-1:0] inl_mem [BINS];
  logic [K_W-1:0]          k_q, k_in;
  logic [CNT_W:0]          hits, target, ideal;
  logic [BIN_W-1:0]        sw_idx;
  logic signed [INL_W-1:0] acc, acc_next;
  logic signed [DNL_W-1:0] sw_dnl;
  logic                    accept;

  function automatic logic signed [DNL_W-1:0] scale_dnl(
    input logic [CNT_W-1:0] c,
    input logic [CNT_W:0]   ideal_c,
    input logic [K_W-1:0]   k
  );
    logic signed [WIDE-1:0] d;
    int sh;
    d  = $signed({{(SCALE+2){1'b0}}, c}) - $signed({{(SCALE+1){1'b0}}, ideal_c});
    sh = SCALE - int'(k);
    if (sh >= 0) d = d <<< sh;
    else         d = d >>> (-sh);
    return d[DNL_W-1:0];
  endfunction

  assign k_in   = (target_log2 < K_W'(K_MIN)) ? K_W'(K_MIN) :
                  (target_log2 > K_W'(K_MAX)) ? K_W'(K_MAX) : target_log2;
  assign target = (CNT_W+1)'(1) << k_q;
  assign ideal  = target >> BIN_W;
  assign busy   = (state == S_COLLECT);
  assign accept = busy && code_valid && !start;

  assign sw_dnl   = scale_dnl(bin_cnt[sw_idx], ideal, k_q);
  assign acc_next = acc + {{BIN_W{sw_dnl[DNL_W-1]}}, sw_dnl};

  always_ff @(posedge clk) begin
    if (start) begin
      for (int i = 0; i < BINS; i++) bin_cnt[i] <= '0;
    end else if (accept && (bin_cnt[code] != {CNT_W{1'b1}})) begin
      bin_cnt[code] <= bin_cnt[code] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_SWEEP) inl_mem[sw_idx] <= acc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      k_q         <= K_W'(K_MIN);
      hits        <= '0;
      sw_idx      <= '0;
      acc         <= '0;
      done        <= 1'b0;
      ready       <= 1'b0;
      any_missing <= 1'b0;
    end else if (start) begin
      state       <= S_COLLECT;
      k_q         <= k_in;
      hits        <= '0;
      done        <= 1'b0;
      ready       <= 1'b0;
      any_missing <= 1'b0;
    end else begin
      case (state)
        S_COLLECT: if (accept) begin
          hits <= hits + 1'b1;
          if ((hits + 1'b1) == target) begin
            state  <= S_SWEEP;
            done   <= 1'b1;
            sw_idx <= '0;
            acc    <= '0;
          end
        end
        S_SWEEP: begin
          acc    <= acc_next;
          sw_idx <= sw_idx + 1'b1;
          if (bin_cnt[sw_idx] == '0) any_missing <= 1'b1;
          if (sw_idx == BIN_W'(BINS-1)) begin
            state <= S_HOLD;
            ready <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    rd_count   <= bin_cnt[rd_idx];
    rd_dnl     <= scale_dnl(bin_cnt[rd_idx], ideal, k_q);
    rd_inl     <= inl_mem[rd_idx];
    rd_missing <= (bin_cnt[rd_idx] == '0);
  end

endmodule

module cdt_histogram_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic code_valid,
  input logic busy,
  input logic done,
  input logic ready,
  input logic any_missing
);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && !ready));

  assert_done_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy && code_valid && !start));

  assert_busy_done_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_ready_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> done);

  assert_missing_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(any_missing));

endmodule

bind cdt_histogram cdt_histogram_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .code_valid(code_valid),
  .busy(busy), .done(done), .ready(ready), .any_missing(any_missing)
);

// File: tb/cdt_histogram_tb.sv
`timescale 1ns/1ps
module cdt_histogram_tb;
  localparam int BINS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] target_log2 = '0;
  logic code_valid = 1'b0;
  logic [6:0] code = '0;
  logic [6:0] rd_idx = '0;
  logic busy, done, ready, any_missing, rd_missing;
  logic [19:0] rd_count;
  logic signed [16:0] rd_dnl;
  logic signed [23:0] rd_inl;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int exp_cnt [BINS];

  always #2 clk = ~clk;

  cdt_histogram u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_log2(target_log2),
    .code_valid(code_valid), .code(code), .rd_idx(rd_idx),
    .busy(busy), .done(done), .ready(ready), .any_missing(any_missing),
    .rd_count(rd_count), .rd_dnl(rd_dnl), .rd_inl(rd_inl), .rd_missing(rd_missing)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_dnl(input int c, input int k);
    longint diff = longint'(c) - (longint'(1) << (k - 7));
    longint div;
    if (k <= 15) return diff * (longint'(1) << (15 - k));
    div = longint'(1) << (k - 15);
    if (diff >= 0) return diff / div;
    return -((-diff + div - 1) / div);
  endfunction

  task automatic begin_run(input int k_prog, input bit hit_in_start);
    target_log2 = 5'(k_prog);
    start = 1'b1;
    code_valid = hit_in_start;
    code = '0;
    tick();
    start = 1'b0;
    code_valid = 1'b0;
    check("R2 busy after start", busy, 1);
    check("R2 done low after start", done, 0);
  endtask

  task automatic feed_hits();
    int total = 0;
    int last = 0;
    for (int b = 0; b < BINS; b++) total += exp_cnt[b];
    for (int b = 0; b < BINS; b++) begin
      for (int n = 0; n < exp_cnt[b]; n++) begin
        last++;
        if (last == total) check("R4 done not before last hit", done, 0);
        code_valid = 1'b1;
        code = 7'(b);
        tick();
      end
    end
    code_valid = 1'b0;
    check("R4 done after last hit", done, 1);
    check("R4 busy low after last hit", busy, 0);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 1000) begin
      tick();
      n++;
    end
    check("R9 ready delay", n, 128);
  endtask

  task automatic verify_all(input int k);
    longint inl = 0;
    bit anym = 1'b0;
    for (int b = 0; b < BINS; b++) begin
      rd_idx = 7'(b);
      tick();
      inl += exp_dnl(exp_cnt[b], k);
      if (exp_cnt[b] == 0) anym = 1'b1;
      check("R3 R10 count", rd_count, exp_cnt[b]);
      check("R6 dnl", rd_dnl, exp_dnl(exp_cnt[b], k));
      check("R7 inl", rd_inl, inl);
      check("R8 missing", rd_missing, exp_cnt[b] == 0);
    end
    check("R8 any_missing", any_missing, anym);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 ready", ready, 0);
    rst_n = 1'b1;
    tick();

    // R5: hits before any start are not counted, stay idle
    code_valid = 1'b1; code = 7'd9;
    repeat (3) tick();
    code_valid = 1'b0;
    check("R5 idle stays not busy", busy, 0);

    // Uniform fill, exponent 3 clamps to 7 (N=128); hit in start cycle ignored (R2)
    for (int b = 0; b < BINS; b++) exp_cnt[b] = 1;
    begin_run(3, 1'b1);
    feed_hits();
    wait_ready();
    // R5: hits after done are ignored
    code_valid = 1'b1; code = 7'd3;
    repeat (5) tick();
    code_valid = 1'b0;
    check("R9 ready held", ready, 1);
    verify_all(7);

    // N=256 with bin 5 empty and bin 6 doubled
    for (int b = 0; b < BINS; b++) exp_cnt[b] = 2;
    exp_cnt[5] = 0;
    exp_cnt[6] = 4;
    begin_run(8, 1'b0);
    feed_hits();
    wait_ready();
    verify_all(8);

    // N=65536: right-shift scaling, floor of negative fraction
    for (int b = 0; b < BINS; b++) exp_cnt[b] = 512;
    exp_cnt[0] = 513;
    exp_cnt[1] = 511;
    begin_run(16, 1'b0);
    feed_hits();
    wait_ready();
    verify_all(16);

    // Exponent above range clamps to 20: a short run must not finish
    for (int b = 0; b < BINS; b++) exp_cnt[b] = 4;
    begin_run(31, 1'b0);
    for (int b = 0; b < BINS; b++) begin
      code_valid = 1'b1; code = 7'(b);
      repeat (4) tick();
    end
    code_valid = 1'b0;
    check("R4 clamp high keeps busy", busy, 1);
    check("R4 clamp high no done", done, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule